// File: doc/BRIEF.md
# Rotate-Left-Through-Carry Register Operation

This block carries out one instruction: rotate a data-memory byte left by one bit, passing the bit through the carry flag. It takes one instruction word per cycle, together with the current bank select value and the status byte. It decodes the instruction and forms the full data address from the instruction's 8-bit file field. In the same cycle it presents that address on a read port and receives the byte combinationally.

The rotated byte goes to one of two destinations. When the direction bit is 0 it is written to the working register. When the direction bit is 1 it is written back to the source location. The addressing bit chooses between two ways of forming the address. With the bit at 0, the fixed access window is used: low file addresses map to bank 0 and high file addresses map to the top bank. With the bit at 1, the bank comes from the bank select input.

All write-back strobes, data and the updated status byte are registered. They appear one cycle after the instruction is accepted. The processor's register file and data memory consume them from there.

Top module: `rlc_rotate_exec`

## Requirements
- R1: The instruction is recognised only when `instrValid` is 1 and `instrWord[15:10]` equals 6'b001101. In every other cycle, `wbWregEn`, `wbMemEn` and `flagsEn` are all 0 on the following cycle.
- R2: For a recognised instruction, `wbData` holds the result on the next cycle. Result bit n+1 equals source bit n for n = 0..6, and result bit 0 equals the incoming carry, `statusIn[0]`.
- R3: On the cycle after a recognised instruction, `flagsEn` is 1 and `statusOut[0]` (carry) equals source bit 7.
- R4: On that same cycle, `statusOut[4]` (negative) equals result bit 7, and `statusOut[2]` (zero) is 1 exactly when the result is 0x00. Bits 1, 3, 5, 6 and 7 of `statusOut` equal the same bits of `statusIn`.
- R5: When `instrWord[9]` (direction) is 0, the next cycle shows `wbWregEn` = 1 and `wbMemEn` = 0.
- R6: When `instrWord[9]` is 1, the next cycle shows `wbMemEn` = 1 and `wbWregEn` = 0, and `wbAddr` equals the address that was read.
- R7: When `instrWord[8]` (addressing) is 0, the upper bank bits of `rdAddr[11:0]` do not depend on `bankSel`. They are 4'h0 when file bit 7 is 0 and 4'hF when it is 1. The low 8 bits of `rdAddr` are the file field.
- R8: When `instrWord[8]` is 1, `rdAddr` equals {`bankSel`, file field}.
- R9: `rdAddr` is valid in the same cycle as the instruction, and all write-back outputs follow exactly one clock later.
- R10: While `rstN` is low, and on the first cycle after it is released, all enables are 0 and `wbData`, `wbAddr` and `statusOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is present this cycle |
| instrWord | input | 16 | Instruction word |
| bankSel | input | 4 | Current bank select value |
| statusIn | input | 8 | Current status byte (bit 0 carry, bit 2 zero, bit 4 negative) |
| rdAddr | output | 12 | Data memory read address |
| rdData | input | 8 | Data memory read byte, combinational from rdAddr |
| wbWregEn | output | 1 | Write the result to the working register |
| wbMemEn | output | 1 | Write the result to data memory |
| wbAddr | output | 12 | Data memory write address |
| wbData | output | 8 | Rotated result |
| flagsEn | output | 1 | Status byte update strobe |
| statusOut | output | 8 | Updated status byte |

## Verification
On every cycle, the bound checker covers the following:
- the opcode gating and destination steering;
- the carry-out and passed-through status bits;
- the match between the write address and the read address;
- the bank bits of the read address in both addressing modes.

The bench covers what needs chosen scenarios:
- every source byte with both carry values, under all four direction and addressing combinations;
- the zero-result corner case, where source 0x00 or 0x80 meets carry 0;
- near-miss opcodes;
- the reset values.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  // Opcode occupies instruction bits [15:10]
  localparam logic [5:0] RLC_OPCODE = 6'b001101;
  localparam int INSTR_W = 16;
  localparam int FILE_W = 8;
  localparam int DIR_BIT = 9;
  localparam int ACC_BIT = 8;
  // Status byte layout
  localparam int C_BIT = 0;
  localparam int Z_BIT = 2;
  localparam int N_BIT = 4;

  typedef struct packed {
    logic hit;     // recognised instruction this cycle
    logic toWreg;  // destination is the working register
  } rlcStrobes_t;
endpackage

// File: rtl/rlc_ctrl.sv
module rlc_ctrl
  import rlc_pkg::*;
#(
  parameter int BANK_W = 4,
  localparam int ADDR_W = BANK_W + FILE_W
) (
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [BANK_W-1:0]  bankSel,
  output rlcStrobes_t        strobes,
  output logic [ADDR_W-1:0]  rdAddr
);
  logic [FILE_W-1:0] fileField;
  logic              useBsr;
  logic [BANK_W-1:0] accessBank;

  assign fileField = instrWord[FILE_W-1:0];
  assign useBsr    = instrWord[ACC_BIT];

  // Access window: lower half of the file space to bank 0, upper half to top bank
  assign accessBank = fileField[FILE_W-1] ? {BANK_W{1'b1}} : {BANK_W{1'b0}};

  always_comb begin
    strobes.hit    = instrValid && (instrWord[INSTR_W-1:INSTR_W-6] == RLC_OPCODE);
    strobes.toWreg = ~instrWord[DIR_BIT];
    rdAddr         = {(useBsr ? bankSel : accessBank), fileField};
  end
endmodule

// File: rtl/rlc_dp.sv
module rlc_dp
  import rlc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  rlcStrobes_t       strobes,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic [7:0]        statusIn,
  output logic              wbWregEn,
  output logic              wbMemEn,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [DATA_W-1:0] wbData,
  output logic              flagsEn,
  output logic [7:0]        statusOut
);
  logic [DATA_W-1:0] rotated;
  logic [7:0]        nextStatus;

  assign rotated[0] = statusIn[C_BIT];
  for (genvar i = 1; i < DATA_W; i++) begin : g_rot
    assign rotated[i] = rdData[i-1];
  end

  always_comb begin
    nextStatus        = statusIn;
    nextStatus[C_BIT] = rdData[DATA_W-1];
    nextStatus[Z_BIT] = (rotated == '0);
    nextStatus[N_BIT] = rotated[DATA_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wbWregEn  <= 1'b0;
      wbMemEn   <= 1'b0;
      flagsEn   <= 1'b0;
      wbAddr    <= '0;
      wbData    <= '0;
      statusOut <= '0;
    end else begin
      wbWregEn <= strobes.hit && strobes.toWreg;
      wbMemEn  <= strobes.hit && !strobes.toWreg;
      flagsEn  <= strobes.hit;
      if (strobes.hit) begin
        wbAddr    <= rdAddr;
        wbData    <= rotated;
        statusOut <= nextStatus;
      end
    end
  end
endmodule

// File: rtl/rlc_rotate_exec.sv
module rlc_rotate_exec
  import rlc_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int DATA_W = 8,
  localparam int ADDR_W = BANK_W + FILE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [BANK_W-1:0]  bankSel,
  input  logic [7:0]         statusIn,
  output logic [ADDR_W-1:0]  rdAddr,
  input  logic [DATA_W-1:0]  rdData,
  output logic               wbWregEn,
  output logic               wbMemEn,
  output logic [ADDR_W-1:0]  wbAddr,
  output logic [DATA_W-1:0]  wbData,
  output logic               flagsEn,
  output logic [7:0]         statusOut
);
  rlcStrobes_t strobes;

  rlc_ctrl #(.BANK_W(BANK_W)) u_ctrl (
    .instrValid(instrValid),
    .instrWord (instrWord),
    .bankSel   (bankSel),
    .strobes   (strobes),
    .rdAddr    (rdAddr)
  );

  rlc_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .statusIn (statusIn),
    .wbWregEn (wbWregEn),
    .wbMemEn  (wbMemEn),
    .wbAddr   (wbAddr),
    .wbData   (wbData),
    .flagsEn  (flagsEn),
    .statusOut(statusOut)
  );
endmodule

// File: rtl/rlc_rotate_checks.sv
module rlc_rotate_checks (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [15:0] instrWord,
  input logic [3:0]  bankSel,
  input logic [7:0]  statusIn,
  input logic [11:0] rdAddr,
  input logic [7:0]  rdData,
  input logic        wbWregEn,
  input logic        wbMemEn,
  input logic [11:0] wbAddr,
  input logic [7:0]  wbData,
  input logic        flagsEn,
  input logic [7:0]  statusOut
);
  logic hitNow;
  assign hitNow = instrValid && (instrWord[15:10] == 6'b001101);

  assert_no_hit_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hitNow |=> !wbWregEn && !wbMemEn && !flagsEn);

  assert_rotate_R2: assert property (@(posedge clk) disable iff (!rstN)
    hitNow |=> wbData == {$past(rdData[6:0]), $past(statusIn[0])});

  assert_carry_R3: assert property (@(posedge clk) disable iff (!rstN)
    hitNow |=> flagsEn && statusOut[0] == $past(rdData[7]));

  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rstN)
    hitNow |=> {statusOut[7:5], statusOut[3], statusOut[1]} ==
               {$past(statusIn[7:5]), $past(statusIn[3]), $past(statusIn[1])});

  assert_to_wreg_R5: assert property (@(posedge clk) disable iff (!rstN)
    hitNow && !instrWord[9] |=> wbWregEn && !wbMemEn);

  assert_to_mem_R6: assert property (@(posedge clk) disable iff (!rstN)
    hitNow && instrWord[9] |=> wbMemEn && !wbWregEn && wbAddr == $past(rdAddr));

  assert_access_bank_R7: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && !instrWord[8] |->
      rdAddr[11:8] == (instrWord[7] ? 4'hF : 4'h0) && rdAddr[7:0] == instrWord[7:0]);

  assert_bsr_bank_R8: assert property (@(posedge clk) disable iff (!rstN)
    instrValid && instrWord[8] |-> rdAddr == {bankSel, instrWord[7:0]});
endmodule

bind rlc_rotate_exec rlc_rotate_checks u_chk (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
  .bankSel(bankSel), .statusIn(statusIn), .rdAddr(rdAddr), .rdData(rdData),
  .wbWregEn(wbWregEn), .wbMemEn(wbMemEn), .wbAddr(wbAddr), .wbData(wbData),
  .flagsEn(flagsEn), .statusOut(statusOut)
);

// File: tb/sim_rlc_rotate_exec.sv
module sim_rlc_rotate_exec;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [3:0]  bankSel = '0;
  logic [7:0]  statusIn = '0;
  logic [11:0] rdAddr;
  logic [7:0]  rdData = '0;
  logic        wbWregEn, wbMemEn, flagsEn;
  logic [11:0] wbAddr;
  logic [7:0]  wbData, statusOut;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rlc_rotate_exec u0 (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .bankSel(bankSel), .statusIn(statusIn), .rdAddr(rdAddr), .rdData(rdData),
    .wbWregEn(wbWregEn), .wbMemEn(wbMemEn), .wbAddr(wbAddr), .wbData(wbData),
    .flagsEn(flagsEn), .statusOut(statusOut)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One instruction: drive at a falling edge, check address, then check results
  task automatic runOp(input logic [15:0] iw, input logic [3:0] bsr,
                       input logic [7:0] st, input logic [7:0] src);
    logic        hit;
    logic        dirMem;
    logic [11:0] expAddr;
    logic [7:0]  expRes;
    logic [7:0]  expSt;
    hit    = (iw[15:10] == 6'b001101);
    dirMem = iw[9];
    if (iw[8]) expAddr = {bsr, iw[7:0]};                           // R8
    else       expAddr = {(iw[7] ? 4'hF : 4'h0), iw[7:0]};         // R7
    expRes = (src << 1) | {7'd0, st[0]};
    expSt  = st;
    expSt[0] = src[7];
    expSt[2] = (expRes == 8'd0);
    expSt[4] = expRes[7];
    @(negedge clk);
    instrWord = iw; bankSel = bsr; statusIn = st; rdData = src; instrValid = 1'b1;
    #1;
    check(iw[8] ? "R8" : "R7", "rdAddr", rdAddr, expAddr);
    @(negedge clk);
    instrValid = 1'b0;
    if (!hit) begin
      check("R1", "enables", {wbWregEn, wbMemEn, flagsEn}, 3'b000);
    end else begin
      check("R2", "wbData", wbData, expRes);
      check("R3", "carry", statusOut[0], src[7]);
      check("R4", "status", statusOut, expSt);
      check("R9", "flagsEn", flagsEn, 1'b1);
      if (dirMem) begin
        check("R6", "enables", {wbWregEn, wbMemEn}, 2'b01);
        check("R6", "wbAddr", wbAddr, expAddr);
      end else begin
        check("R5", "enables", {wbWregEn, wbMemEn}, 2'b10);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "reset enables", {wbWregEn, wbMemEn, flagsEn}, 3'b000);
    check("R10", "reset data", {wbData, wbAddr, statusOut}, '0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10", "post-reset enables", {wbWregEn, wbMemEn, flagsEn}, 3'b000);

    // Fixed example: 0xE6 with carry 0 to the working register
    runOp({6'b001101, 1'b0, 1'b0, 8'h25}, 4'h3, 8'h00, 8'hE6);
    check("R2", "example result", wbData, 8'hCC);

    // Sweep every byte, both carries, all direction and addressing combinations
    for (int d = 0; d < 2; d++)
      for (int a = 0; a < 2; a++)
        for (int c = 0; c < 2; c++)
          for (int v = 0; v < 256; v++) begin
            logic [7:0] f;
            logic [7:0] st;
            f  = 8'(v * 37 + d * 64 + a * 3);
            st = 8'({v[3:0], 4'b0} ^ 8'hAA) & 8'hEA;
            st[0] = c[0];
            runOp({6'b001101, d[0], a[0], f}, 4'(v + c), st, 8'(v));
          end

    // Access window boundary file addresses
    runOp({6'b001101, 1'b1, 1'b0, 8'h7F}, 4'h9, 8'h01, 8'h80);
    runOp({6'b001101, 1'b1, 1'b0, 8'h80}, 4'h9, 8'h00, 8'h80);

    // Near-miss opcodes and invalid cycles produce no write-back
    for (int k = 0; k < 6; k++)
      runOp({(6'b001101 ^ (6'd1 << k)), 2'b11, 8'h10}, 4'h2, 8'h01, 8'h55);
    @(negedge clk);
    instrWord = {6'b001101, 2'b10, 8'h44};
    instrValid = 1'b0;
    @(negedge clk);
    check("R1", "invalid word", {wbWregEn, wbMemEn, flagsEn}, 3'b000);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule